// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a network DMA engine. It takes a byte stream from the MAC, one frame at a time, and scatters it into fixed 128-byte data buffers in system memory. A ring of descriptors describes those buffers. Each descriptor is two 32-bit words at an 8-byte stride. The address word holds the buffer base, with bits [6:0] free for flags. Bit 0 of the address word is the ownership flag: 0 means the buffer belongs to the hardware, 1 means software owns it. Bit 1 of the address word marks the last entry of the ring. The status word reports how the frame sits in the buffers.

The ring starts at `ring_base`. While `rx_en` is low the walking pointer is reloaded from that base and no new frame is started. For each buffer, the block reads the address word, refuses a software-owned buffer, and fills a free one. It then writes the address word back with the ownership flag set, and writes the status word. It raises a frame-complete flag when a frame ends, and a no-buffer flag when the ring has no free entry. Both flags are cleared by writing 1. A configuration input can keep the trailing 4-byte frame check sequence out of memory and out of the length.

Memory is reached through a simple port. Reads return data on `mem_rdata` one clock after the request. Writes take effect at the request edge and carry byte enables.

Top module: `rx_ring_writer`

## Requirements
- R1: During and after reset, `rx_ready`, `mem_req`, `stat_rcomp` and `stat_bna` are all 0.
- R2: A frame that waits at `rx_valid` while the block is idle and enabled first causes a read (`mem_we`=0) of the address word at the current pointer. `rx_ready` stays 0 until that word shows a free buffer.
- R3: Stored byte k of a buffer goes to byte address base+k. The bytes are packed little-endian into 32-bit words. `mem_be` covers only the valid bytes of a partial last word, so memory past the last stored byte is left untouched.
- R4: A buffer holds at most 128 bytes. A longer frame continues at offset 0 of the buffer of the next descriptor.
- R5: When a buffer is closed, its address word is written back unchanged except that bit 0 is set. Its status word (address word + 4) is then written as follows: bit 14 is set on the first buffer of the frame. Bit 15 is set on the last buffer. Bits [11:0] hold the stored frame length on the last buffer and 0 on the others.
- R6: After a buffer is closed, the pointer moves on by 8. If bit 1 of that descriptor's address word was set, the pointer returns to `ring_base` instead.
- R7: If the first descriptor of a frame is software-owned, `stat_bna` is set and the whole frame is accepted and discarded with no memory write. The pointer stays on that descriptor.
- R8: If a descriptor needed in the middle of a frame is software-owned, `stat_bna` is set and the rest of the frame is discarded. The buffers already closed keep their start mark, have no end mark and have length 0. The pointer stays on the owned descriptor, and `stat_rcomp` is not set.
- R9: `stat_rcomp` is set once the status word of a frame's last buffer has been written.
- R10: With `strip_fcs` high, the last 4 bytes of each frame are neither written nor counted in the length.
- R11: `stat_clr` bit 0 clears `stat_rcomp` and bit 1 clears `stat_bna`. A 0 bit leaves its flag as it is, and a flag being set in the same cycle wins over the clear.
- R12: While `rx_en` is low, a waiting frame is not started: `rx_ready` and `mem_req` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_en | input | 1 | Receive enable; low holds the pointer at `ring_base` |
| strip_fcs | input | 1 | Keep the 4 trailing check bytes out of memory and length |
| ring_base | input | 32 | Byte address of descriptor 0, 8-byte aligned |
| rx_valid | input | 1 | A frame byte is offered |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Offered byte is the last of its frame |
| rx_ready | output | 1 | Offered byte is taken at this edge |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_be | output | 4 | Byte enables of a write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one clock after a read request |
| stat_clr | input | 2 | Write-1-to-clear strobe: bit 0 frame-complete, bit 1 no-buffer |
| stat_rcomp | output | 1 | Frame-complete flag |
| stat_bna | output | 1 | No-free-buffer flag |

## Verification
The assertions take for granted that `mem_rdata` carries the word read at the previous edge, that `ring_base` is 8-byte aligned, and that it does not change while a frame is in flight. With `strip_fcs` high they also assume each frame is longer than 4 bytes. The stimulus keeps within this: its memory model answers every read with one-clock latency, and it changes the base only while `rx_en` is low. Every stripped frame is at least 64 bytes long. Software-side ring edits, such as releasing descriptors or marking them owned, happen only while the block is idle.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WAITD, S_FILL, S_ADDR, S_STAT, S_DROP
  } rxr_state_e;

  localparam int OWN_BIT     = 0;
  localparam int LASTD_BIT   = 1;
  localparam int FIRST_BIT   = 14;
  localparam int END_BIT     = 15;
  localparam int DESC_STRIDE = 8;
  localparam int STAT_OFS    = 4;
endpackage

// File: rtl/rxr_fcs_hold.sv
module rxr_fcs_hold #(
  parameter int HOLD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       last,
  input  logic [7:0] din,
  input  logic       strip,
  output logic       emit,
  output logic [7:0] dout
);
  localparam int CW = $clog2(HOLD + 1);

  logic [7:0]    sh_q [HOLD];
  logic [7:0]    sh_d [HOLD];
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (take) begin
      sh_d[0] = din;
      for (int k = 1; k < HOLD; k++) sh_d[k] = sh_q[k-1];
      if (last)                     cnt_d = '0;
      else if (cnt_q != CW'(HOLD))  cnt_d = cnt_q + CW'(1);
    end
  end

  assign emit = take && (!strip || cnt_q == CW'(HOLD));
  assign dout = strip ? sh_q[HOLD-1] : din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int k = 0; k < HOLD; k++) sh_q[k] <= '0;
    end else if (take) begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  // R10: a frame end empties the hold line so the next frame's first bytes stay held
  a_r10_hold_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last) |=> (cnt_q == '0));
endmodule

// File: rtl/rxr_packer.sv
module rxr_packer #(
  parameter int BUF_BYTES = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  open,
  input  logic                  emit,
  input  logic [7:0]            byte_in,
  input  logic                  last,
  output logic                  wr,
  output logic [31:0]           wdata,
  output logic [3:0]            be,
  output logic [$clog2(BUF_BYTES)-3:0] word_idx,
  output logic                  full_now
);
  localparam int OFF_W = $clog2(BUF_BYTES);

  logic [OFF_W-1:0] off_q, off_d;
  logic [23:0]      pack_q, pack_d;
  logic [1:0]       fill;
  logic [2:0]       new_cnt;

  assign fill    = off_q[1:0];
  assign new_cnt = {1'b0, fill} + {2'b00, emit};
  assign wr      = (new_cnt == 3'd4) || (last && new_cnt != 3'd0);
  assign word_idx = off_q[OFF_W-1:2];
  assign full_now = emit && (off_q == OFF_W'(BUF_BYTES - 1));

  always_comb begin
    wdata = {8'h00, pack_q};
    if (emit) begin
      case (fill)
        2'd0:    wdata[7:0]   = byte_in;
        2'd1:    wdata[15:8]  = byte_in;
        2'd2:    wdata[23:16] = byte_in;
        default: wdata[31:24] = byte_in;
      endcase
    end
    case (new_cnt)
      3'd1:    be = 4'b0001;
      3'd2:    be = 4'b0011;
      3'd3:    be = 4'b0111;
      3'd4:    be = 4'b1111;
      default: be = 4'b0000;
    endcase
  end

  always_comb begin
    off_d  = off_q;
    pack_d = pack_q;
    if (open) begin
      off_d = '0;
    end else if (emit) begin
      off_d = off_q + OFF_W'(1);
      case (fill)
        2'd0:    pack_d[7:0]   = byte_in;
        2'd1:    pack_d[15:8]  = byte_in;
        2'd2:    pack_d[23:16] = byte_in;
        default: pack_d        = pack_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      pack_q <= '0;
    end else if (open || emit) begin
      off_q  <= off_d;
      pack_q <= pack_d;
    end
  end

  // R3: every data write enables a non-empty run of bytes starting at lane 0
  a_r3_be_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (be != 4'b0000) && ((be & 4'(be + 4'd1)) == 4'b0000));
  // R4: a buffer closes on its last byte, so the offset restarts from zero afterwards
  a_r4_offset_restart: assert property (@(posedge clk) disable iff (!rst_n)
    open |=> (off_q == '0));
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic [AW-1:0] ring_base,
  input  logic          rx_valid,
  input  logic          rx_last,
  output logic          rx_ready,
  output logic          take,
  output logic          fill_active,
  output logic          open,
  input  logic          pk_emit,
  input  logic          pk_wr,
  input  logic [31:0]   pk_wdata,
  input  logic [3:0]    pk_be,
  input  logic [$clog2(BUF_BYTES)-3:0] pk_word,
  input  logic          full_now,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic [1:0]    stat_clr,
  output logic          stat_rcomp,
  output logic          stat_bna
);
  localparam int OFF_W = $clog2(BUF_BYTES);

  rxr_state_e     state_q, state_d;
  logic [AW-1:0]  ptr_q, ptr_d;
  logic [31:0]    aw_q, aw_d;
  logic           sof_q, sof_d, eof_q, eof_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic           rcomp_q, bna_q, set_rcomp, set_bna;
  logic [31:0]    stat_word;

  assign fill_active = (state_q == S_FILL);
  assign rx_ready    = fill_active || (state_q == S_DROP);
  assign take        = rx_ready && rx_valid;

  always_comb begin
    stat_word = '0;
    stat_word[LEN_W-1:0] = eof_q ? len_q : '0;
    stat_word[FIRST_BIT] = sof_q;
    stat_word[END_BIT]   = eof_q;
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr_q;
    mem_be    = 4'b1111;
    mem_wdata = '0;
    case (state_q)
      S_FETCH: mem_req = 1'b1;
      S_FILL: begin
        mem_req   = pk_wr;
        mem_we    = pk_wr;
        mem_addr  = {aw_q[AW-1:OFF_W], pk_word, 2'b00};
        mem_be    = pk_be;
        mem_wdata = pk_wdata;
      end
      S_ADDR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = aw_q | 32'd1;
      end
      S_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr_q + AW'(STAT_OFS);
        mem_wdata = stat_word;
      end
      default: ;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    ptr_d     = ptr_q;
    aw_d      = aw_q;
    sof_d     = sof_q;
    eof_d     = eof_q;
    len_d     = len_q;
    open      = 1'b0;
    set_rcomp = 1'b0;
    set_bna   = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (!rx_en) ptr_d = ring_base;
        else if (rx_valid) begin
          state_d = S_FETCH;
          sof_d   = 1'b1;
          len_d   = '0;
        end
      end
      S_FETCH: state_d = S_WAITD;
      S_WAITD: begin
        if (mem_rdata[OWN_BIT]) begin
          set_bna = 1'b1;
          state_d = S_DROP;
        end else begin
          aw_d    = mem_rdata;
          open    = 1'b1;
          state_d = S_FILL;
        end
      end
      S_FILL: begin
        if (take) begin
          if (pk_emit) len_d = len_q + LEN_W'(1);
          if (rx_last) begin
            eof_d   = 1'b1;
            state_d = S_ADDR;
          end else if (full_now) begin
            eof_d   = 1'b0;
            state_d = S_ADDR;
          end
        end
      end
      S_ADDR: state_d = S_STAT;
      S_STAT: begin
        ptr_d = aw_q[LASTD_BIT] ? ring_base : ptr_q + AW'(DESC_STRIDE);
        sof_d = 1'b0;
        if (eof_q) begin
          set_rcomp = 1'b1;
          state_d   = S_IDLE;
        end else begin
          state_d = S_FETCH;
        end
      end
      S_DROP: if (take && rx_last) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      aw_q    <= '0;
      sof_q   <= 1'b0;
      eof_q   <= 1'b0;
      len_q   <= '0;
      rcomp_q <= 1'b0;
      bna_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      aw_q    <= aw_d;
      sof_q   <= sof_d;
      eof_q   <= eof_d;
      len_q   <= len_d;
      rcomp_q <= set_rcomp | (rcomp_q & ~stat_clr[0]);
      bna_q   <= set_bna   | (bna_q   & ~stat_clr[1]);
    end
  end

  assign stat_rcomp = rcomp_q;
  assign stat_bna   = bna_q;

  // R2: filling only begins after the fetched word showed a hardware-owned buffer
  a_r2_owned_before_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FILL && $past(state_q) == S_WAITD) |-> !$past(mem_rdata[OWN_BIT]));
  // R6: plain step to the next descriptor
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == S_STAT && !$past(aw_q[LASTD_BIT])) |->
      (ptr_q == $past(ptr_q) + AW'(DESC_STRIDE)));
  // R6: ring end returns to the base
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == S_STAT && $past(aw_q[LASTD_BIT])) |-> (ptr_q == $past(ring_base)));
  // R7 / R8: an owned descriptor raises the flag and freezes the pointer
  a_r7_bna_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAITD && mem_rdata[OWN_BIT]) |=> (stat_bna && $stable(ptr_q)));
  // R9: closing the last buffer of a frame raises the completion flag
  a_r9_rcomp: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == S_STAT && $past(eof_q)) |-> stat_rcomp);
  // R11: a clear with no competing set empties the flag
  a_r11_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr[0] && state_q != S_STAT) |=> !stat_rcomp);
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 12,
  parameter int FCS_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          strip_fcs,
  input  logic [AW-1:0] ring_base,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  output logic          rx_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic [1:0]    stat_clr,
  output logic          stat_rcomp,
  output logic          stat_bna
);
  localparam int OFF_W = $clog2(BUF_BYTES);

  logic [1:0] rs_q;
  logic       srst_n;
  logic       take, fill_active, open, hold_emit, pk_emit, pk_last;
  logic [7:0] hold_byte;
  logic       pk_wr, full_now;
  logic [31:0] pk_wdata;
  logic [3:0]  pk_be;
  logic [OFF_W-3:0] pk_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  assign pk_emit = hold_emit & fill_active;
  assign pk_last = take & rx_last & fill_active;

  rxr_fcs_hold #(.HOLD(FCS_BYTES)) u_hold (
    .clk(clk), .rst_n(srst_n), .take(take), .last(rx_last), .din(rx_data),
    .strip(strip_fcs), .emit(hold_emit), .dout(hold_byte)
  );

  rxr_packer #(.BUF_BYTES(BUF_BYTES)) u_pack (
    .clk(clk), .rst_n(srst_n), .open(open), .emit(pk_emit), .byte_in(hold_byte),
    .last(pk_last), .wr(pk_wr), .wdata(pk_wdata), .be(pk_be), .word_idx(pk_word),
    .full_now(full_now)
  );

  rxr_ctrl #(.AW(AW), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(srst_n), .rx_en(rx_en), .ring_base(ring_base),
    .rx_valid(rx_valid), .rx_last(rx_last), .rx_ready(rx_ready), .take(take),
    .fill_active(fill_active), .open(open), .pk_emit(pk_emit), .pk_wr(pk_wr),
    .pk_wdata(pk_wdata), .pk_be(pk_be), .pk_word(pk_word), .full_now(full_now),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .stat_clr(stat_clr),
    .stat_rcomp(stat_rcomp), .stat_bna(stat_bna)
  );

  // R1: nothing moves on the memory port while reset is held inside
  a_r1_quiet_reset: assert property (@(posedge clk)
    !srst_n |-> (!mem_req && !rx_ready));
endmodule

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
  localparam int NV = 8;
  localparam int V_LEN    [NV] = '{60, 64, 128, 129, 300, 132, 133, 61};
  localparam int V_STRIP  [NV] = '{0,  1,  0,   0,   0,   1,   1,   0};
  localparam int V_STORED [NV] = '{60, 60, 128, 129, 300, 128, 129, 61};
  localparam int BASE = 32'h20;
  localparam int BUF0 = 32'h200;

  logic clk = 1'b0;
  logic rst_n, rx_en, strip_fcs, rx_valid, rx_last, rx_ready;
  logic [7:0] rx_data;
  logic [31:0] ring_base;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic [1:0] stat_clr;
  logic stat_rcomp, stat_bna;
  logic [31:0] mem [512];
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  rx_ring_writer u_rx_ring_writer (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .strip_fcs(strip_fcs),
    .ring_base(ring_base), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .stat_clr(stat_clr), .stat_rcomp(stat_rcomp),
    .stat_bna(stat_bna)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[10:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end else if (mem_req) begin
      mem_rdata <= mem[mem_addr[10:2]];
    end
  end

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed + i * 7);
  endfunction

  function automatic logic [7:0] rd_byte(input int addr);
    return mem[addr[10:2]][(addr % 4) * 8 +: 8];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic init_ring();
    for (int i = 0; i < 4; i++) begin
      mem[(BASE + 8 * i) / 4]     = BUF0 + 32'h80 * i + ((i == 3) ? 2 : 0);
      mem[(BASE + 8 * i + 4) / 4] = 32'h0;
    end
    for (int w = BUF0 / 4; w < 256; w++) mem[w] = 32'hEEEE_EEEE;
  endtask

  task automatic restart();
    @(negedge clk); rx_en = 1'b0;
    init_ring();
    repeat (2) @(negedge clk);
    rx_en = 1'b1;
  endtask

  task automatic pulse_clr(input logic [1:0] v);
    @(negedge clk); stat_clr = v;
    @(negedge clk); stat_clr = 2'b00;
  endtask

  task automatic send_frame(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = pat(seed, i); rx_last = (i == len - 1);
      #1;
      while (!rx_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b0; strip_fcs = 1'b0; ring_base = BASE;
    rx_valid = 1'b0; rx_last = 1'b0; rx_data = '0; stat_clr = 2'b00;
    for (int w = 0; w < 512; w++) mem[w] = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'd0, rx_ready}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle outputs", {28'd0, rx_ready, mem_req, stat_rcomp, stat_bna}, 32'd0);

    // R12 then R2: held frame ignored while disabled, then fetch comes first
    init_ring();
    rx_valid = 1'b1; rx_data = pat(5, 0); rx_last = 1'b0;
    begin
      logic seen = 1'b0;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk); #1;
        if (rx_ready || mem_req) seen = 1'b1;
      end
      chk("R12 no start while disabled", {31'd0, seen}, 32'd0);
    end
    @(negedge clk); rx_en = 1'b1;
    @(negedge clk); #1;
    chk("R2 descriptor read first", {rx_ready, mem_req, mem_we, mem_addr[28:0]},
        {1'b0, 1'b1, 1'b0, 29'(BASE)});
    send_frame(20, 5);
    chk("R2 frame landed", mem[(BASE + 4) / 4], 32'h0000_C014);
    pulse_clr(2'b01);

    // table of frame vectors
    for (int v = 0; v < NV; v++) begin
      int nbuf, errs, stored;
      stored = V_STORED[v];
      nbuf = (stored + 127) / 128;
      strip_fcs = V_STRIP[v][0];
      restart();
      send_frame(V_LEN[v], 16 * v + 3);
      for (int j = 0; j < nbuf; j++) begin
        int exp_len;
        exp_len = (j == nbuf - 1) ? stored : 0;
        chk($sformatf("R5 owned v%0d b%0d", v, j), mem[(BASE + 8 * j) / 4],
            BUF0 + 32'h80 * j + ((j == 3) ? 2 : 0) + 1);
        chk($sformatf("R5 status v%0d b%0d", v, j), mem[(BASE + 8 * j + 4) / 4],
            32'((j == 0) << 14) | 32'((j == nbuf - 1) << 15) | 32'(exp_len));
      end
      chk($sformatf("R4 next free v%0d", v), {31'd0, mem[(BASE + 8 * nbuf) / 4][0]}, 32'd0);
      errs = 0;
      for (int i = 0; i < stored; i++)
        if (rd_byte(BUF0 + 128 * (i / 128) + i % 128) !== pat(16 * v + 3, i)) errs++;
      chk($sformatf("R3 R4 data v%0d", v), 32'(errs), 32'd0);
      if (stored % 128 != 0)
        chk($sformatf("R10 R3 guard byte v%0d", v),
            {24'd0, rd_byte(BUF0 + 128 * (stored / 128) + stored % 128)}, 32'hEE);
      chk($sformatf("R9 rcomp v%0d", v), {31'd0, stat_rcomp}, 32'd1);
      pulse_clr(2'b10);
      chk($sformatf("R11 zero bit keeps v%0d", v), {31'd0, stat_rcomp}, 32'd1);
      pulse_clr(2'b01);
      chk($sformatf("R11 clear v%0d", v), {31'd0, stat_rcomp}, 32'd0);
    end
    strip_fcs = 1'b0;

    // R6 / R7: fill the whole ring, hit an owned descriptor, then wrap
    restart();
    for (int f = 0; f < 4; f++) send_frame(100, 10 * (f + 1));
    chk("R6 last entry status", mem[(BASE + 28) / 4], 32'h0000_C064);
    pulse_clr(2'b01);
    send_frame(40, 50);
    chk("R7 bna raised", {31'd0, stat_bna}, 32'd1);
    chk("R7 no completion", {31'd0, stat_rcomp}, 32'd0);
    chk("R7 buffer untouched", {24'd0, rd_byte(BUF0)}, {24'd0, pat(10, 0)});
    pulse_clr(2'b10);
    chk("R11 bna cleared", {31'd0, stat_bna}, 32'd0);
    mem[BASE / 4] = BUF0; mem[BASE / 4 + 1] = 32'h0;
    send_frame(40, 60);
    chk("R6 wrapped to base", {24'd0, rd_byte(BUF0)}, {24'd0, pat(60, 0)});
    chk("R6 wrapped status", mem[BASE / 4 + 1], 32'h0000_C028);
    pulse_clr(2'b01);

    // R8: ownership lost in the middle of a frame
    @(negedge clk); rx_en = 1'b0;
    init_ring();
    mem[(BASE + 8) / 4] = BUF0 + 32'h81;
    repeat (2) @(negedge clk); rx_en = 1'b1;
    send_frame(200, 70);
    chk("R8 first buffer start only", mem[(BASE + 4) / 4], 32'h0000_4000);
    chk("R8 bna raised", {31'd0, stat_bna}, 32'd1);
    chk("R8 no completion", {31'd0, stat_rcomp}, 32'd0);
    pulse_clr(2'b10);
    mem[(BASE + 8) / 4] = BUF0 + 32'h80;
    send_frame(50, 90);
    chk("R8 pointer stayed", mem[(BASE + 12) / 4], 32'h0000_C032);
    chk("R8 data in second buffer", {24'd0, rd_byte(BUF0 + 32'h80)}, {24'd0, pat(90, 0)});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule